// File: doc/BRIEF.md
# Four-Level Strap Address Decoder

This block works out the low four bits of a two-wire bus target address from two strap pins. Each pin may be tied low, tied high, wired to the bus clock line (SCL) or wired to the bus data line (SDA). The block tells these four cases apart by watching each pin across a whole bus transmission, from START to STOP.

The block decodes every transmission on the bus, whatever device it targets. The result is registered at STOP. It gives a 4-bit address suffix and the full 7-bit address, which has a fixed upper part. The same result drives one pull-up enable for each nibble of an eight-port register.

During power-on reset the block samples the straps as plain levels. A pin wired to a bus line reads high at that time, because the idle bus is high. That first reading also sets the reset-default level of each port nibble, and these defaults are held from then on.

Top module: `strap_addr_decode`

## Requirements
- R1: While rst_n is low, each strap is classed by its level alone (1 = high, 0 = low). A pin wired to an idle bus line is therefore classed as high until the first transmission decodes it.
- R2: dev_addr is the fixed prefix 3'b110 followed by addr_sfx, so its range is 0x60 to 0x6F.
- R3: Strap A gives addr_sfx[1:0] with this encoding: low = 00, high = 01, SCL = 10, SDA = 11.
- R4: Strap B gives addr_sfx[3:2] with this encoding: SCL = 00, SDA = 01, low = 10, high = 11.
- R5: A strap is classed as SCL if it equalled scl on every sample from the START cycle through the STOP cycle, and scl was low on at least one of those samples. This check has priority over R6 and R7.
- R6: A strap that fails R5 is classed as SDA if it equalled sda on every sample of the window, and sda was low on at least one of them.
- R7: A strap that tracked neither line is classed by its level in the STOP cycle. This holds even if the pin toggled during the transmission.
- R8: The decode updates only on the clock edge that takes a stop_pulse inside an open window. A START pulse opens a window, and a START pulse inside an open window (repeated start) is ignored. addr_sfx is unchanged during a transmission, and a stop_pulse with no open window has no effect.
- R9: pullup_en[0] (ports 3..0, from strap A) and pullup_en[1] (ports 7..4, from strap B) are 1 when the latest class of that strap is high, SCL or SDA, and 0 when it is low.
- R10: port_dflt[0] (strap A) and port_dflt[1] (strap B) hold the strap levels captured during reset. Later decodes never change them.
- R11: Every transmission is decoded anew, so a changed strap wiring shows up after the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| strap_a | input | 1 | Sampled strap pin for suffix bits 1:0, ports 3..0 |
| strap_b | input | 1 | Sampled strap pin for suffix bits 3:2, ports 7..4 |
| scl | input | 1 | Sampled bus clock line |
| sda | input | 1 | Sampled bus data line |
| start_pulse | input | 1 | One-cycle START strobe |
| stop_pulse | input | 1 | One-cycle STOP strobe |
| addr_sfx | output | 4 | Decoded low address bits |
| dev_addr | output | 7 | Full 7-bit target address |
| pullup_en | output | 2 | Pull-up enable per port nibble |
| port_dflt | output | 2 | Reset-default level per port nibble |

## Verification
The assertions assume three things about the inputs:
- start_pulse and stop_pulse are single-cycle strobes.
- Straps, scl and sda are already synchronous to clk.
- A STOP that closes a window is the only event that may move the address.

The stimulus builds every transmission as a START cycle, a sequence of clock-low and clock-high bit cycles and a STOP cycle. It raises the strobes only in those cycles. A stray STOP and a repeated START are injected on purpose, to check that both are ignored.

Pins that toggle freely are forced away from both bus lines on the first two samples. This keeps them out of the SCL and SDA classes, so their expected class is set only by their level at STOP.

// File: rtl/strap_addr_decode.sv
module strap_addr_decode #(
  parameter logic [2:0] ADDR_HI = 3'b110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_a,
  input  logic       strap_b,
  input  logic       scl,
  input  logic       sda,
  input  logic       start_pulse,
  input  logic       stop_pulse,
  output logic [3:0] addr_sfx,
  output logic [6:0] dev_addr,
  output logic [1:0] pullup_en,
  output logic [1:0] port_dflt
);

  localparam logic [1:0] K_LOW  = 2'd0;
  localparam logic [1:0] K_HIGH = 2'd1;
  localparam logic [1:0] K_SCL  = 2'd2;
  localparam logic [1:0] K_SDA  = 2'd3;

  logic [1:0] pin;
  logic       busy;
  logic       scl_lo_q, sda_lo_q;
  logic       scl_lo_n, sda_lo_n;
  logic [1:0] trk_scl_q, trk_sda_q;
  logic [1:0] trk_scl_n, trk_sda_n;
  logic [1:0] cls_q [2];
  logic [1:0] cls_nx [2];
  logic [1:0] dflt_q;

  assign pin      = {strap_b, strap_a};
  assign scl_lo_n = scl_lo_q | ~scl;
  assign sda_lo_n = sda_lo_q | ~sda;

  for (genvar i = 0; i < 2; i++) begin : g_pin
    assign trk_scl_n[i] = trk_scl_q[i] & (pin[i] == scl);
    assign trk_sda_n[i] = trk_sda_q[i] & (pin[i] == sda);
    always_comb begin
      if (trk_scl_n[i] && scl_lo_n)      cls_nx[i] = K_SCL;
      else if (trk_sda_n[i] && sda_lo_n) cls_nx[i] = K_SDA;
      else if (pin[i])                   cls_nx[i] = K_HIGH;
      else                               cls_nx[i] = K_LOW;
    end
    assign pullup_en[i] = (cls_q[i] != K_LOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      scl_lo_q  <= 1'b0;
      sda_lo_q  <= 1'b0;
      trk_scl_q <= '0;
      trk_sda_q <= '0;
      cls_q[0]  <= {1'b0, pin[0]};
      cls_q[1]  <= {1'b0, pin[1]};
      dflt_q    <= pin;
    end else if (busy && stop_pulse) begin
      busy     <= 1'b0;
      cls_q[0] <= cls_nx[0];
      cls_q[1] <= cls_nx[1];
    end else if (!busy && start_pulse) begin
      busy      <= 1'b1;
      scl_lo_q  <= ~scl;
      sda_lo_q  <= ~sda;
      trk_scl_q <= {pin[1] == scl, pin[0] == scl};
      trk_sda_q <= {pin[1] == sda, pin[0] == sda};
    end else if (busy) begin
      scl_lo_q  <= scl_lo_n;
      sda_lo_q  <= sda_lo_n;
      trk_scl_q <= trk_scl_n;
      trk_sda_q <= trk_sda_n;
    end
  end

  assign addr_sfx  = {cls_q[1] ^ 2'b10, cls_q[0]};
  assign dev_addr  = {ADDR_HI, addr_sfx};
  assign port_dflt = dflt_q;

endmodule

// File: rtl/strap_addr_chk.sv
module strap_addr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_pulse,
  input logic       busy,
  input logic [3:0] addr_sfx,
  input logic [6:0] dev_addr,
  input logic [1:0] pullup_en,
  input logic [1:0] port_dflt
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  a_r8_addr_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$stable(addr_sfx) |-> $past(stop_pulse) && $past(busy));

  a_r8_stop_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop_pulse |=> !busy);

  a_r10_dflt_held: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> $stable(port_dflt));

  a_r9_pullup_lo: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en[0] == (addr_sfx[1:0] != 2'b00));

  a_r9_pullup_hi: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en[1] == (addr_sfx[3:2] != 2'b10));

  a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    dev_addr[3:0] == addr_sfx && dev_addr[6:4] == 3'b110);
endmodule

bind strap_addr_decode strap_addr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_pulse(stop_pulse), .busy(busy),
  .addr_sfx(addr_sfx), .dev_addr(dev_addr), .pullup_en(pullup_en),
  .port_dflt(port_dflt)
);

// File: tb/test_strap_addr_decode.sv
module test_strap_addr_decode;
  logic clk = 0, rst_n = 0;
  logic strap_a = 1, strap_b = 0, scl = 1, sda = 1;
  logic start_pulse = 0, stop_pulse = 0;
  logic [3:0] addr_sfx;
  logic [6:0] dev_addr;
  logic [1:0] pullup_en, port_dflt;
  int total = 0, bad = 0;
  int ka, kb, la, lb, cyc;

  localparam int LOW = 0, HIGH = 1, SCLK = 2, SDAK = 3, NOISE = 4;

  always #5 clk = ~clk;

  strap_addr_decode i_strap_addr_decode (.*);

  function automatic logic [1:0] code_a(int k);
    case (k) LOW: return 2'b00; HIGH: return 2'b01; SCLK: return 2'b10; default: return 2'b11; endcase
  endfunction
  function automatic logic [1:0] code_b(int k);
    case (k) SCLK: return 2'b00; SDAK: return 2'b01; LOW: return 2'b10; default: return 2'b11; endcase
  endfunction
  function automatic int resolve(int k, int lvl);
    if (k == NOISE) return lvl ? HIGH : LOW;
    return k;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pinv(int k, int lvl, bit last);
    case (k)
      LOW:  return 1'b0;
      HIGH: return 1'b1;
      SCLK: return scl;
      SDAK: return sda;
      default: begin
        if (cyc < 2) return 1'b1;
        if (last) return lvl[0];
        return 1'($urandom);
      end
    endcase
  endfunction

  task automatic tick(logic c, logic d, logic st, logic sp);
    @(negedge clk);
    scl = c; sda = d; start_pulse = st; stop_pulse = sp;
    strap_a = pinv(ka, la, sp);
    strap_b = pinv(kb, lb, sp);
    cyc++;
  endtask

  task automatic txn(int nbytes, bit rep_start, logic [3:0] hold_exp);
    cyc = 0;
    tick(1, 0, 1, 0);
    cyc = 1;
    for (int b = 0; b < nbytes * 9; b++) begin
      logic bitv;
      bitv = 1'($urandom);
      tick(0, bitv, 0, 0);
      tick(1, bitv, 0, 0);
      if (b == 4) check("R8 mid-transaction", addr_sfx, hold_exp);
    end
    if (rep_start) begin
      tick(0, 1, 0, 0);
      tick(1, 1, 0, 0);
      tick(1, 0, 1, 0);
      check("R8 repeated start", addr_sfx, hold_exp);
    end
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 1);
    tick(1, 1, 0, 0);
  endtask

  task automatic expect_txn(string tag, int a, int b, int al, int bl);
    logic [3:0] e;
    e = {code_b(resolve(b, bl)), code_a(resolve(a, al))};
    check({tag, " R3 R4 R11 suffix"}, addr_sfx, e);
    check({tag, " R2 address"}, dev_addr, {3'b110, e});
    check({tag, " R9 pullups"}, pullup_en,
          {resolve(b, bl) != LOW, resolve(a, al) != LOW});
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    void'($urandom(32'h5eed_1234));
    ka = HIGH; kb = LOW; la = 1; lb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset suffix", addr_sfx, 4'b1001);
    check("R1 reset pullups", pullup_en, 2'b01);
    check("R10 reset dflt", port_dflt, 2'b01);
    check("R2 reset address", dev_addr, 7'h69);

    ka = SCLK; kb = SDAK;
    txn(2, 0, 4'b1001);
    expect_txn("R5 R6 scl/sda", SCLK, SDAK, 0, 0);
    check("R10 dflt after decode", port_dflt, 2'b01);

    ka = SDAK; kb = SCLK;
    txn(1, 1, 4'b0110);
    expect_txn("R5 R6 swapped", SDAK, SCLK, 0, 0);

    prev = addr_sfx;
    ka = HIGH; kb = HIGH;
    tick(1, 1, 0, 1);
    tick(1, 1, 0, 0);
    check("R8 stray stop ignored", addr_sfx, prev);

    ka = NOISE; kb = NOISE; la = 1; lb = 0;
    txn(2, 0, prev);
    expect_txn("R7 toggling pins", NOISE, NOISE, 1, 0);

    for (int n = 0; n < 40; n++) begin
      prev = addr_sfx;
      ka = $urandom_range(0, 4); kb = $urandom_range(0, 4);
      la = $urandom_range(0, 1); lb = $urandom_range(0, 1);
      txn($urandom_range(1, 3), 1'($urandom), prev);
      expect_txn("random", ka, kb, la, lb);
      check("R10 dflt held", port_dflt, 2'b01);
    end

    @(negedge clk);
    rst_n = 0; strap_a = 0; strap_b = 1; ka = LOW; kb = HIGH;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 second reset suffix", addr_sfx, 4'b1100);
    check("R10 second reset dflt", port_dflt, 2'b10);
    check("R9 second reset pullups", pullup_en, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule